// File: doc/BRIEF.md
# Fixed-Period Winding Current Chopper

This block produces the switch gate for one motor winding under constant-current control. A counter divides the system clock into chop periods of fixed length. At the start of every period a set-reset latch is set, which turns the winding switch on. When the current in the winding has risen far enough, an external analog comparator reports that the sense voltage has reached the reference. That report resets the latch, and the switch then stays off until the next period begins. The switch is never turned back on inside the same period.

For a short window at the start of each period, called the blanking window, trips from the comparator are ignored. This hides the switching spike. It also means the switch is on for a minimum time in every period, even when the reference is zero, and that minimum sets the lowest holding current. The gate is the latch output ANDed with the phase command and with the enable. A phase command that is inactive holds the latch reset.

The comparator and the reference DAC are outside this block. The comparator output passes through a two-flop synchronizer before it is used.

Top module: `chop_ctrl`

## Requirements
- R1: After reset the gate is low. The first chop period starts DIV clock cycles after reset is released, and every later period is exactly DIV cycles long.
- R2: At each period start, if the phase command is high, the latch is set. The gate is high in the first cycle of the period when the enable is high.
- R3: The gate equals latch AND phase command AND enable, with no added delay. Enable low forces the gate low in that same cycle.
- R4: A comparator trip seen after the blanking window resets the latch. The gate then stays low for the rest of the period, even if the trip goes away.
- R5: Comparator trips seen during the first BLANK cycles of a period are ignored.
- R6: If the comparator is held high without a break, the gate is high for exactly BLANK+1 cycles in each period.
- R7: The comparator input passes through two flip-flops. A trip that is first sampled at clock edge k, after blanking, takes the gate low from clock edge k+2 onward.
- R8: While the phase command is low, the latch is held reset. When the command returns in the middle of a period, the gate stays low until the next period start.
- R9: When a set and a reset of the latch fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Drive enable; when low the gate is forced low |
| phase_cmd | input | 1 | Phase command for this winding |
| cmp_trip | input | 1 | Comparator output, asynchronous; high when the sense voltage has reached the reference |
| gate | output | 1 | Switch gate drive |

## Verification
The bench places single-cycle comparator pulses on both sides of the blanking boundary. A design that blanks for one cycle too many or too few would either hold the gate on through a trip that should count, or cut it off on a trip that should be ignored. With the comparator held high across period starts, a design where reset wins over set would never turn the gate on at all. Dropping the phase command mid-period and then restoring it catches a design that re-arms the latch and emits a partial pulse. Toggling the enable with no clock edge in between catches a gate that has been registered by mistake.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int DIV   = 17,
  parameter int BLANK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic phase_cmd,
  input  logic cmp_trip,
  output logic gate
);
  localparam int CW = $clog2(DIV);
  localparam int BW = $clog2(BLANK + 2);

  logic [CW-1:0] cnt;
  logic [BW-1:0] blk;
  logic          cmp_s1, cmp_s2;
  logic          lat;
  logic          start, trip;

  assign start = (cnt == CW'(DIV - 1));
  assign trip  = cmp_s2 && (blk == '0);
  assign gate  = lat & phase_cmd & en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= start ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          blk <= '0;
    else if (start)      blk <= BW'(BLANK);
    else if (blk != '0)  blk <= blk - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_s1 <= 1'b0;
      cmp_s2 <= 1'b0;
    end else begin
      cmp_s1 <= cmp_trip;
      cmp_s2 <= cmp_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          lat <= 1'b0;
    else if (!phase_cmd) lat <= 1'b0;
    else if (start)      lat <= 1'b1;
    else if (trip)       lat <= 1'b0;

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DIV));

  p_set_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat) |-> cnt == '0);

  p_no_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat && !start) |=> !lat);

  p_blank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && blk != '0 && phase_cmd) |=> lat);

  p_trip_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_s2 && blk == '0 && !start) |=> !lat);

  p_phase_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_cmd |=> !lat);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase_cmd) |=> lat);
endmodule

// File: tb/test_chop_ctrl.sv
module test_chop_ctrl;
  localparam int DIV = 17;
  localparam int BLANK = 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, phase_cmd = 1'b0, cmp_trip = 1'b0;
  logic gate;
  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  int m_cnt = 0, m_blk = 0, m_lat = 0;
  bit sync_q[$] = '{1'b0, 1'b0};

  chop_ctrl #(.DIV(DIV), .BLANK(BLANK)) i_chop_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_cmd(phase_cmd),
    .cmp_trip(cmp_trip), .gate(gate));

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_blk = 0; m_lat = 0;
      sync_q = '{1'b0, 1'b0};
    end else begin
      bit seen;
      bit at_start;
      seen = sync_q.pop_front();
      sync_q.push_back(cmp_trip);
      at_start = (m_cnt == DIV - 1);
      if (!phase_cmd) m_lat = 0;
      else if (at_start) m_lat = 1;
      else if (seen && m_blk == 0) m_lat = 0;
      if (at_start) m_blk = BLANK;
      else if (m_blk > 0) m_blk = m_blk - 1;
      m_cnt = at_start ? 0 : m_cnt + 1;
    end
  end

  task automatic check(input logic exp, input string req);
    checks++;
    if (gate !== exp) begin
      fails++;
      $display("FAIL %s gate=%b expected=%b at cycle %0d", req, gate, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    #1;
    cycles++;
    check(logic'(m_lat == 1 && phase_cmd && en), cur_req);
  end

  task automatic wait_cnt(input int n);
    do @(negedge clk); while (m_cnt != n);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    summary();
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    phase_cmd = 1'b1; en = 1'b1;
    repeat (DIV - 1) begin @(negedge clk); #1; check(1'b0, "R1"); end
    @(negedge clk); #1; check(1'b1, "R2");
    cur_req = "R2";
    wait_cnt(DIV - 2);
    cur_req = "R4";
    wait_cnt(BLANK + 3); cmp_trip = 1'b1;
    @(negedge clk); cmp_trip = 1'b0;
    @(negedge clk); #1; check(1'b1, "R7");
    @(negedge clk); #1; check(1'b0, "R7");
    wait_cnt(DIV - 1); #1; check(1'b0, "R4");
    cur_req = "R5";
    wait_cnt(0); cmp_trip = 1'b1;
    wait_cnt(BLANK - 2 >= 0 ? BLANK - 2 : 0); cmp_trip = 1'b0;
    wait_cnt(DIV - 2); #1; check(1'b1, "R5");
    cur_req = "R6";
    cmp_trip = 1'b1;
    wait_cnt(DIV - 1);
    for (int p = 0; p < 3; p++) begin
      hi = 0;
      for (int c = 0; c < DIV; c++) begin @(negedge clk); #1; if (gate) hi++; end
      checks++;
      if (hi != BLANK + 1) begin
        fails++;
        $display("FAIL R6 on-cycles=%0d expected=%0d", hi, BLANK + 1);
      end
    end
    cur_req = "R9";
    wait_cnt(0); #1; check(1'b1, "R9");
    cmp_trip = 1'b0;
    cur_req = "R3";
    wait_cnt(3); en = 1'b0; #1; check(1'b0, "R3");
    @(negedge clk); en = 1'b1; #1; check(1'b1, "R3");
    cur_req = "R8";
    wait_cnt(5); phase_cmd = 1'b0; #1; check(1'b0, "R8");
    @(negedge clk); @(negedge clk); phase_cmd = 1'b1; #1; check(1'b0, "R8");
    wait_cnt(DIV - 1); #1; check(1'b0, "R8");
    wait_cnt(0); #1; check(1'b1, "R8");
    repeat (DIV) @(negedge clk);
    summary();
  end
endmodule